// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital half of an 8-bit successive approximation analog-to-digital converter. It drives a trial code to an external DAC and sample-and-hold stage and reads back one comparator bit. It settles the result one bit at a time, starting at the most significant bit. Each trial turns on the bit under test on top of the bits already kept. The comparator then decides whether that bit stays set.

A conversion runs on a fixed timeline of 32 clocks:
- a 12-clock tracking window, with the hold control high;
- a 4-clock trial for bit 7;
- 2-clock trials for bits 6 down to 0;
- a 2-clock closing step.

After the closing step the final code is presented on the result port with a one-clock done pulse. The caller starts a conversion with a one-clock start pulse while the block is idle. The analog parts (DAC, comparator, references) sit outside the block.

Top module: `sar_conv_ctrl`

## Requirements
- R1: While reset (active low, synchronous) is asserted and on the first cycle after it is released, trial_o is 0x00, track_o is 0, result_o is 0x00 and done_o is 0.
- R2: A start_i pulse seen at a clock edge while idle makes track_o high for exactly the next 12 clocks, and trial_o reads 0x00 during those 12 clocks.
- R3: For the 4 clocks after the tracking window, trial_o is 0x80.
- R4: Bits 6 down to 0 are each tried for 2 clocks, in descending order. During the trial of bit k, trial_o equals the bits already kept above k, with bit k set and all bits below k clear.
- R5: cmp_i = 1 means the analog input is at or above the trial level. cmp_i is sampled only on the last clock of each bit trial. A 1 keeps the bit under test and a 0 clears it. Values on earlier clocks of a step have no effect.
- R6: After bit 0 is decided, trial_o shows the final code for a 2-clock closing step. done_o is then high for exactly one clock, 32 clocks after the start edge, and result_o takes the final code on that same clock. result_o changes on no other clock.
- R7: With an ideal comparator, result_o equals the input code across the full range, including 0x00 (bottom of range) and 0xFF (top of range).
- R8: A start_i pulse during a running conversion (tracking, trials or closing step) is ignored. The timeline and result are unchanged.
- R9: After done_o, the block is idle with track_o low, and the next start_i pulse begins a new conversion with the same timeline.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Conversion request pulse, honoured only while idle |
| cmp_i | input | 1 | Comparator result: 1 when the input is at or above the trial level |
| trial_o | output | 8 | Trial code driven to the external DAC |
| track_o | output | 1 | Sample-and-hold tracking control, high during the tracking window |
| result_o | output | 8 | Last completed conversion code |
| done_o | output | 1 | One-clock pulse marking a new result |

## Verification
The bench checks the trial code on every clock of each conversion against a model of the timeline. A design with a wrong MSB step length, or one that tried bits at one per clock, would show a shifted trial sequence and a late or early done.

One test makes the comparator lie on every clock of each step except the last. A design that samples cmp_i too early would then produce a corrupted code instead of the input value.

Start pulses are injected during tracking and during the trials. A design that restarted would shorten the trace and miss the expected done clock.

The end-of-range codes 0x00 and 0xFF, and patterns such as 0x7F and 0x80, target a bit being kept or cleared in the wrong polarity or at the wrong index.

// File: rtl/sar_conv_pkg.sv
// Shared types for the successive approximation controller.
// Assumes nothing beyond a single clock domain.
package sar_conv_pkg;

    // Phases of one conversion
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_TRACK  = 2'd1,
        PH_TRIAL  = 2'd2,
        PH_CLOSE  = 2'd3
    } phase_t;

    // Largest of four step lengths, used to size the phase counter
    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sar_step_sequencer.sv
// Timeline sequencer: walks idle -> track -> bit trials -> close -> idle.
// Issues one-clock strobes that tell the trial register when to clear,
// when to open the MSB trial, when to decide a bit, and when the result
// is final. Assumes start_i is synchronous to clk.
module sar_step_sequencer
    import sar_conv_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int TRACK_CLKS  = 12,
    parameter int MSB_CLKS    = 4,
    parameter int BIT_CLKS    = 2,
    parameter int CLOSE_CLKS  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    output phase_t                   phase_o,
    output logic                     clear_o,
    output logic                     open_o,
    output logic                     decide_o,
    output logic [$clog2(WIDTH)-1:0] bit_idx_o,
    output logic                     final_o
);

    localparam int MAX_CLKS = max_of4(TRACK_CLKS, MSB_CLKS, BIT_CLKS, CLOSE_CLKS);
    localparam int CNT_W    = $clog2(MAX_CLKS + 1);
    localparam int IDX_W    = $clog2(WIDTH);

    phase_t            phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [CNT_W-1:0]  step_last;
    logic              track_end;

    // Length of the current bit trial minus one: MSB step is longer
    always_comb begin
        if (idx_q == IDX_W'(WIDTH - 1))
            step_last = CNT_W'(MSB_CLKS - 1);
        else
            step_last = CNT_W'(BIT_CLKS - 1);
    end

    // Strobes decoded from the registered phase and counter
    always_comb begin
        clear_o   = (phase_q == PH_IDLE) && start_i;
        track_end = (phase_q == PH_TRACK) && (cnt_q == CNT_W'(TRACK_CLKS - 1));
        open_o    = track_end;
        decide_o  = (phase_q == PH_TRIAL) && (cnt_q == step_last);
        final_o   = (phase_q == PH_CLOSE) && (cnt_q == CNT_W'(CLOSE_CLKS - 1));
    end

    // Phase, step counter and bit index advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    cnt_q <= '0;
                    if (start_i) phase_q <= PH_TRACK;
                end
                PH_TRACK: begin
                    if (track_end) begin
                        phase_q <= PH_TRIAL;
                        cnt_q   <= '0;
                        idx_q   <= IDX_W'(WIDTH - 1);
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_TRIAL: begin
                    if (decide_o) begin
                        cnt_q <= '0;
                        if (idx_q == '0) phase_q <= PH_CLOSE;
                        else             idx_q   <= idx_q - 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_CLOSE: begin
                    if (final_o) begin
                        phase_q <= PH_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase_o   = phase_q;
    assign bit_idx_o = idx_q;

    // R2: an accepted start opens the tracking window at count zero
    p_track_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clear_o |=> (phase_q == PH_TRACK) && (cnt_q == '0));

    // R3: the first trial after tracking is the MSB
    p_msb_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        open_o |=> (phase_q == PH_TRIAL) && (idx_q == IDX_W'(WIDTH - 1)));

    // R8: a running conversion never falls back to idle before its end
    p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE) && !final_o |=> (phase_q != PH_IDLE));

    // R4: bit index only moves downward, one step at a time
    p_idx_descends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_TRIAL) && decide_o && (idx_q != '0) |=> (idx_q == $past(idx_q) - 1'b1));

endmodule

// File: rtl/sar_trial_register.sv
// Successive approximation register: holds the trial code sent to the DAC.
// On open it sets the MSB; on each decide it keeps or clears the bit under
// test from the comparator and sets the next lower bit. Assumes cmp_i is
// stable around the clock edge on which decide_i is high.
module sar_trial_register #(
    parameter int WIDTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear_i,
    input  logic                     open_i,
    input  logic                     decide_i,
    input  logic [$clog2(WIDTH)-1:0] bit_idx_i,
    input  logic                     cmp_i,
    output logic [WIDTH-1:0]         trial_o
);

    localparam int IDX_W = $clog2(WIDTH);

    logic [WIDTH-1:0] trial_q;
    logic [WIDTH-1:0] trial_d;

    // Next trial code from the current strobe
    always_comb begin
        trial_d = trial_q;
        if (clear_i) begin
            trial_d = '0;
        end else if (open_i) begin
            trial_d[WIDTH-1] = 1'b1;
        end else if (decide_i) begin
            if (!cmp_i) trial_d[bit_idx_i] = 1'b0;
            if (bit_idx_i != '0) trial_d[bit_idx_i - IDX_W'(1)] = 1'b1;
        end
    end

    // Trial code register
    always_ff @(posedge clk) begin
        if (!rst_n) trial_q <= '0;
        else        trial_q <= trial_d;
    end

    assign trial_o = trial_q;

    // R5: a high comparator on a decide edge keeps the bit under test
    p_keep_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        decide_i && cmp_i |=> trial_q[$past(bit_idx_i)]);

    // R5: a low comparator on a decide edge clears the bit under test
    p_drop_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        decide_i && !cmp_i |=> !trial_q[$past(bit_idx_i)]);

    // R4: a decision touches at most the tested bit and the next one
    p_two_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        decide_i |=> ($countones(trial_q ^ $past(trial_q)) <= 2));

    // R5: outside a strobe the trial code holds
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i && !open_i && !decide_i |=> $stable(trial_q));

endmodule

// File: rtl/sar_result_latch.sv
// Captures the final trial code when the close step ends and raises a
// one-clock done pulse. Assumes final_i is a single-clock strobe.
module sar_result_latch #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             final_i,
    input  logic [WIDTH-1:0] trial_i,
    output logic [WIDTH-1:0] result_o,
    output logic             done_o
);

    // Result capture and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= final_i;
            if (final_i) result_o <= trial_i;
        end
    end

    // R6: done is a single-clock pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: the result moves only together with done
    p_result_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_o) |-> done_o);

endmodule

// File: rtl/sar_conv_ctrl.sv
// Top of the successive approximation conversion controller.
// Ties the timeline sequencer, the trial register and the result latch
// together and decodes the sample-and-hold control. Assumes an external
// comparator answers cmp_i = 1 when the analog input >= DAC(trial_o).
module sar_conv_ctrl
    import sar_conv_pkg::*;
#(
    parameter int WIDTH      = 8,
    parameter int TRACK_CLKS = 12,
    parameter int MSB_CLKS   = 4,
    parameter int BIT_CLKS   = 2,
    parameter int CLOSE_CLKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cmp_i,
    output logic [WIDTH-1:0] trial_o,
    output logic             track_o,
    output logic [WIDTH-1:0] result_o,
    output logic             done_o
);

    localparam int IDX_W = $clog2(WIDTH);

    phase_t           phase;
    logic             clear_s;
    logic             open_s;
    logic             decide_s;
    logic [IDX_W-1:0] bit_idx;
    logic             final_s;

    sar_step_sequencer #(
        .WIDTH      (WIDTH),
        .TRACK_CLKS (TRACK_CLKS),
        .MSB_CLKS   (MSB_CLKS),
        .BIT_CLKS   (BIT_CLKS),
        .CLOSE_CLKS (CLOSE_CLKS)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .phase_o   (phase),
        .clear_o   (clear_s),
        .open_o    (open_s),
        .decide_o  (decide_s),
        .bit_idx_o (bit_idx),
        .final_o   (final_s)
    );

    sar_trial_register #(
        .WIDTH (WIDTH)
    ) sar_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear_s),
        .open_i    (open_s),
        .decide_i  (decide_s),
        .bit_idx_i (bit_idx),
        .cmp_i     (cmp_i),
        .trial_o   (trial_o)
    );

    sar_result_latch #(
        .WIDTH (WIDTH)
    ) res_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .final_i  (final_s),
        .trial_i  (trial_o),
        .result_o (result_o),
        .done_o   (done_o)
    );

    // Sample-and-hold tracks only during the tracking window
    always_comb track_o = (phase == PH_TRACK);

    // R2: the trial code is zero while the sample-and-hold tracks
    p_zero_while_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
        track_o |-> (trial_o == '0));

    // R9: done is only raised once the block is back in idle
    p_idle_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (phase == PH_IDLE) && !track_o);

endmodule

// File: tb/sar_conv_ctrl_tb_top.sv
// Directed bench for the successive approximation controller. An ideal
// comparator is modelled as (vin >= trial_o), optionally inverted on the
// non-final clocks of each bit step.
module sar_conv_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       cmp;
    logic [7:0] vin = 8'h00;
    logic       flip = 1'b0;
    logic [7:0] trial;
    logic       track;
    logic [7:0] result;
    logic       done;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    // Comparator model with optional misleading answers
    always_comb cmp = (vin >= trial) ^ flip;

    sar_conv_ctrl dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .cmp_i    (cmp),
        .trial_o  (trial),
        .track_o  (track),
        .result_o (result),
        .done_o   (done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected trial code on conversion clock c (0 = first tracking clock)
    function automatic logic [7:0] exp_trial(input logic [7:0] v, input int c);
        int k;
        if (c < 12) return 8'h00;
        if (c >= 30) return v;
        if (c < 16) k = 7;
        else        k = 6 - (c - 16) / 2;
        return (v & ~8'((1 << (k + 1)) - 1)) | 8'(1 << k);
    endfunction

    function automatic bit not_last(input int c);
        return (c >= 12 && c <= 14) || (c >= 16 && c <= 28 && (c % 2 == 0));
    endfunction

    function automatic string req_of(input int c);
        if (c < 12) return "R2";
        if (c < 16) return "R3";
        if (c < 30) return "R4";
        return "R6";
    endfunction

    // One conversion, checked clock by clock
    task automatic run_conv(input logic [7:0] v, input bit lie, input bit poke);
        vin = v;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 32; c++) begin
            if (c > 0) @(negedge clk);
            flip  = lie && not_last(c);
            start = poke && (c == 5 || c == 20 || c == 31);
            check(track == (c < 12), (c < 12) ? "R2" : "R9", track, c < 12);
            check(trial == exp_trial(v, c), req_of(c), trial, exp_trial(v, c));
            check(done == 1'b0, "R6", done, 0);
        end
        @(negedge clk);
        flip  = 1'b0;
        start = 1'b0;
        check(done == 1'b1, "R6", done, 1);
        check(result == v, lie ? "R5" : "R7", result, v);
        @(negedge clk);
        check(done == 1'b0, "R6", done, 0);
        check(track == 1'b0, poke ? "R8" : "R9", track, 0);
        check(result == v, "R6", result, v);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(trial == 8'h00, "R1", trial, 0);
        check(track == 1'b0, "R1", track, 0);
        check(done == 1'b0, "R1", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(result == 8'h00, "R1", result, 0);
        check(trial == 8'h00 && !track && !done, "R1", trial, 0);
    endtask

    // R7: range ends and bit patterns with an honest comparator
    task automatic test_codes();
        run_conv(8'h00, 1'b0, 1'b0);
        run_conv(8'hFF, 1'b0, 1'b0);
        run_conv(8'h80, 1'b0, 1'b0);
        run_conv(8'h7F, 1'b0, 1'b0);
        run_conv(8'h60, 1'b0, 1'b0);
        run_conv(8'h01, 1'b0, 1'b0);
    endtask

    // R5: misleading comparator on non-final clocks must not matter
    task automatic test_late_sample();
        run_conv(8'hA5, 1'b1, 1'b0);
        run_conv(8'h5A, 1'b1, 1'b0);
    endtask

    // R8: start pulses during tracking, trials and close are ignored
    task automatic test_busy_start();
        run_conv(8'h3C, 1'b0, 1'b1);
    endtask

    // R9: back-to-back conversions after done
    task automatic test_back_to_back();
        run_conv(8'hC3, 1'b0, 1'b0);
        run_conv(8'h55, 1'b0, 1'b0);
    endtask

    bit finished = 1'b0;

    initial begin
        test_reset();
        test_codes();
        test_late_sample();
        test_busy_start();
        test_back_to_back();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule